// File: doc/BRIEF.md
# Core Reset and FIFO Flush Controller

This block holds the reset-control register of a USB dual-role controller core and turns software writes to it into reset and flush actions. A write can start a whole-core soft reset, a reset of the bus-clock pipelines only, a frame-number restart, a flush of the IN-token learning queue, a receive FIFO flush, or a transmit FIFO flush aimed at one FIFO or at every FIFO. Each request bit reads back as set while its operation is running, then clears on its own. Two read-only bits show the bus-master idle and DMA-request inputs.

The FIFOs, the MAC and the DMA engine are outside the block. The block drives one-cycle flush strobes and a level reset, and it takes a reset-done handshake, a bus-master idle level and a start-of-frame pulse. It also holds the interrupt status, interrupt mask and a configuration register, so the effects of a soft reset on each can be seen at the register port: the mask is wiped, while the status and the configuration survive.

Top module: `rstflush_ctrl`

## Requirements
- R1: After reset, the request bits (0 to 5) and the FIFO-number field (bits 10:6) read 0. The status, mask and configuration registers (addresses 1, 2, 3) read 0, the frame number is 0 and every strobe output is low.
- R2: Writing 1 to bit 4 of the control register (address 0) gives one cycle of `rx_flush_o` in the cycle after the write. Bit 4 then reads 1 for exactly FLUSH_CYC (8) cycles and 0 after that.
- R3: Writing 1 to bit 5 gives a one-cycle `tx_flush_o` pattern in the cycle after the write, and bit 5 reads 1 for FLUSH_CYC cycles. Code values below NUM_TXF set only bit `code` of the pattern (code 0 is the non-periodic FIFO). Code 16 sets all bits. Any other code sets none.
- R4: The FIFO-number field is latched when a transmit flush starts. While that flush is pending, writes to the field and new transmit flush requests have no effect. When no transmit flush is pending, the field can be written without starting a flush.
- R5: Writing 1 to bit 0 starts a soft reset. Bit 0 and `core_rst_o` stay high until the first clock edge at which `rst_done_i` and `mst_idle_i` are both sampled high, and that edge clears them. While the soft reset is pending, writes to the control register are ignored.
- R6: When a soft reset starts, the interrupt mask, request bits 1 to 5 and the FIFO-number field are cleared. In the following cycle `rx_flush_o` and every bit of `tx_flush_o` strobe once. The interrupt status and configuration registers keep their values.
- R7: Bit 2 stays set until the next `sof_i`. That start of frame gives `frm_num_o` = 0. Every other `sof_i` adds 1 to `frm_num_o`, modulo 2^FRM_W.
- R8: Bit 1 gives one cycle of `bus_rst_o` in the cycle after the write and reads 1 for that one cycle. It leaves the frame number, the mask and the status unchanged.
- R9: Bit 3 gives one cycle of `intkn_flush_o` in the cycle after the write and reads 1 for that one cycle.
- R10: Control bit 31 reads `mst_idle_i` and bit 30 reads `dma_req_i`. Writes to these bits are ignored.
- R11: Each 1 in `irq_set_i` sets a status bit. Writing 1s to address 1 clears those bits, but a set in the same cycle wins. `irq_o` is the OR of status AND mask.
- R12: A write that sets bit 0 together with other request bits starts only the soft reset. The other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 mask, 3 configuration) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| dma_req_i | input | 1 | DMA request level, shown at control bit 30 |
| mst_idle_i | input | 1 | Bus master idle level, shown at bit 31 and used for soft-reset completion |
| rst_done_i | input | 1 | Reset-done handshake from the core logic |
| sof_i | input | 1 | Start-of-frame pulse |
| irq_set_i | input | 32 | Interrupt event bits |
| core_rst_o | output | 1 | Core soft reset level |
| bus_rst_o | output | 1 | Bus-domain reset strobe |
| intkn_flush_o | output | 1 | IN-token queue flush strobe |
| rx_flush_o | output | 1 | Receive FIFO flush strobe |
| tx_flush_o | output | NUM_TXF | Transmit FIFO flush strobes, bit 0 non-periodic |
| frm_num_o | output | FRM_W | Current frame number |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `rst_done_i` carries meaning only while a soft reset is pending, and that `sof_i` never needs more than one frame step per cycle. The stimulus changes every input only on the falling edge and keeps `wr_en` and `sof_i` high for a single cycle. It raises `rst_done_i` only while a soft reset is outstanding, so the completion handshake is never seen outside its window. Every transmit FIFO code is swept, and the frame counter is run through a full wrap.

// File: rtl/rstflush_pkg.sv
package rstflush_pkg;

   localparam int unsigned CTRL_W     = 32;
   // control register bit positions (software decodes these)
   localparam int unsigned B_SOFT     = 0;
   localparam int unsigned B_BUS      = 1;
   localparam int unsigned B_FRM      = 2;
   localparam int unsigned B_ITKN     = 3;
   localparam int unsigned B_RXF      = 4;
   localparam int unsigned B_TXF      = 5;
   localparam int unsigned TXSEL_LSB  = 6;
   localparam int unsigned TXSEL_W    = 5;
   localparam int unsigned B_DMAREQ   = 30;
   localparam int unsigned B_MSTIDLE  = 31;

   // self-clearing request channels
   localparam int unsigned CH_BUS  = 0;
   localparam int unsigned CH_ITKN = 1;
   localparam int unsigned CH_RX   = 2;
   localparam int unsigned CH_TX   = 3;
   localparam int unsigned CH_N    = 4;

   typedef enum logic [1:0] {
      RF_CTRL = 2'd0,
      RF_STAT = 2'd1,
      RF_MASK = 2'd2,
      RF_CFG  = 2'd3
   } rf_addr_e;

   function automatic int unsigned ch_bit(input int unsigned ch);
      case (ch)
         CH_BUS:  return B_BUS;
         CH_ITKN: return B_ITKN;
         CH_RX:   return B_RXF;
         default: return B_TXF;
      endcase
   endfunction

endpackage

// File: rtl/rf_self_clear.sv
module rf_self_clear #(
   parameter int unsigned LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic kill,
   output logic busy,
   output logic strobe
);

   localparam int unsigned CNT_W = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("rf_self_clear: LEN must be at least 1");
   end

   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= start & ~kill;
   end

   assign strobe = strobe_q;

   if (LEN == 1) begin : g_single
      // a one-cycle request: the strobe flop doubles as the busy bit
      assign busy = strobe_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             busy_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (kill) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LEN);
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
         end
      end

      assign busy = busy_q;

      p_cnt_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
         busy_q |-> (cnt_q != '0));
   end

   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
   p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> busy);

endmodule

// File: rtl/rf_softrst_seq.sv
module rf_softrst_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done_i,
   input  logic idle_i,
   output logic active,
   output logic entry_stb
);

   logic active_q;
   logic entry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         entry_q  <= 1'b0;
      end else begin
         entry_q <= start;
         if (start)                              active_q <= 1'b1;
         else if (active_q && done_i && idle_i) active_q <= 1'b0;
      end
   end

   assign active    = active_q;
   assign entry_stb = entry_q;

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(done_i && idle_i)) |=> active);
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && done_i && idle_i && !start) |=> !active);
   p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      entry_stb |-> active);

endmodule

// File: rtl/rf_txsel_decode.sv
module rf_txsel_decode #(
   parameter int unsigned NUM_TXF = 16,
   parameter int unsigned SEL_W   = 5
) (
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_TXF-1:0] vec
);

   localparam int unsigned ALL_CODE = 1 << (SEL_W - 1);

   if (NUM_TXF < 1 || NUM_TXF > ALL_CODE) begin : g_bad_cnt
      $error("rf_txsel_decode: NUM_TXF must lie in 1..2**(SEL_W-1)");
   end

   logic all_sel;
   assign all_sel = (sel == SEL_W'(ALL_CODE));

   for (genvar i = 0; i < NUM_TXF; i++) begin : g_bit
      assign vec[i] = all_sel | (sel == SEL_W'(i));
   end

endmodule

// File: rtl/rstflush_ctrl.sv
module rstflush_ctrl
   import rstflush_pkg::*;
#(
   parameter int unsigned NUM_TXF   = 16,
   parameter int unsigned FLUSH_CYC = 8,
   parameter int unsigned FRM_W     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [1:0]         rd_addr,
   output logic [31:0]        rd_data,
   input  logic               dma_req_i,
   input  logic               mst_idle_i,
   input  logic               rst_done_i,
   input  logic               sof_i,
   input  logic [31:0]        irq_set_i,
   output logic               core_rst_o,
   output logic               bus_rst_o,
   output logic               intkn_flush_o,
   output logic               rx_flush_o,
   output logic [NUM_TXF-1:0] tx_flush_o,
   output logic [FRM_W-1:0]   frm_num_o,
   output logic               irq_o
);

   if (FLUSH_CYC < 1 || FRM_W < 1) begin : g_bad_cfg
      $error("rstflush_ctrl: FLUSH_CYC and FRM_W must be at least 1");
   end

   // ---------------- write decode ----------------
   logic wr_ctrl, req_ok, soft_start, frm_start;
   logic wr_stat, wr_mask, wr_cfg;
   logic soft_busy, soft_stb;
   logic [CH_N-1:0] ch_start, ch_busy, ch_stb;

   logic [TXSEL_W-1:0] txnum_q;
   logic               frm_pend_q;
   logic [FRM_W-1:0]   frm_num_q;
   logic [CTRL_W-1:0]  mask_q, stat_q, cfg_q;
   logic [NUM_TXF-1:0] tx_vec;
   logic [CTRL_W-1:0]  ctrl_rd;

   always_comb begin
      wr_ctrl    = wr_en && (wr_addr == RF_CTRL) && !soft_busy;
      soft_start = wr_ctrl && wr_data[B_SOFT];
      req_ok     = wr_ctrl && !wr_data[B_SOFT];
      frm_start  = req_ok && wr_data[B_FRM] && !frm_pend_q;
      wr_stat    = wr_en && (wr_addr == RF_STAT);
      wr_mask    = wr_en && (wr_addr == RF_MASK);
      wr_cfg     = wr_en && (wr_addr == RF_CFG);
   end

   // ---------------- soft reset sequencer ----------------
   rf_softrst_seq u_soft (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (soft_start),
      .done_i    (rst_done_i),
      .idle_i    (mst_idle_i),
      .active    (soft_busy),
      .entry_stb (soft_stb)
   );

   // ---------------- self-clearing request channels ----------------
   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      localparam int unsigned LEN_C = (c >= CH_RX) ? FLUSH_CYC : 1;

      assign ch_start[c] = req_ok && wr_data[ch_bit(c)] && !ch_busy[c];

      rf_self_clear #(.LEN(LEN_C)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (ch_start[c]),
         .kill   (soft_start),
         .busy   (ch_busy[c]),
         .strobe (ch_stb[c])
      );
   end

   // ---------------- transmit FIFO selection ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        txnum_q <= '0;
      else if (soft_start)               txnum_q <= '0;
      else if (req_ok && !ch_busy[CH_TX]) txnum_q <= wr_data[TXSEL_LSB +: TXSEL_W];
   end

   rf_txsel_decode #(.NUM_TXF(NUM_TXF), .SEL_W(TXSEL_W)) u_dec (
      .sel (txnum_q),
      .vec (tx_vec)
   );

   // ---------------- frame counter ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_pend_q <= 1'b0;
         frm_num_q  <= '0;
      end else begin
         if (soft_start)     frm_pend_q <= 1'b0;
         else if (frm_start) frm_pend_q <= 1'b1;
         else if (sof_i)     frm_pend_q <= 1'b0;
         if (sof_i) frm_num_q <= frm_pend_q ? '0 : frm_num_q + 1'b1;
      end
   end

   // ---------------- interrupt and configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (soft_start)   mask_q <= '0;
         else if (wr_mask) mask_q <= wr_data;
         stat_q <= (stat_q & ~(wr_stat ? wr_data : '0)) | irq_set_i;
         if (wr_cfg) cfg_q <= wr_data;
      end
   end

   // ---------------- read mux and outputs ----------------
   always_comb begin
      ctrl_rd                           = '0;
      ctrl_rd[B_SOFT]                   = soft_busy;
      ctrl_rd[B_BUS]                    = ch_busy[CH_BUS];
      ctrl_rd[B_FRM]                    = frm_pend_q;
      ctrl_rd[B_ITKN]                   = ch_busy[CH_ITKN];
      ctrl_rd[B_RXF]                    = ch_busy[CH_RX];
      ctrl_rd[B_TXF]                    = ch_busy[CH_TX];
      ctrl_rd[TXSEL_LSB +: TXSEL_W]     = txnum_q;
      ctrl_rd[B_DMAREQ]                 = dma_req_i;
      ctrl_rd[B_MSTIDLE]                = mst_idle_i;
      case (rd_addr)
         RF_CTRL: rd_data = ctrl_rd;
         RF_STAT: rd_data = stat_q;
         RF_MASK: rd_data = mask_q;
         default: rd_data = cfg_q;
      endcase
   end

   assign core_rst_o    = soft_busy;
   assign bus_rst_o     = ch_stb[CH_BUS];
   assign intkn_flush_o = ch_stb[CH_ITKN];
   assign rx_flush_o    = ch_stb[CH_RX] | soft_stb;
   assign tx_flush_o    = ({NUM_TXF{ch_stb[CH_TX]}} & tx_vec) | {NUM_TXF{soft_stb}};
   assign frm_num_o     = frm_num_q;
   assign irq_o         = |(stat_q & mask_q);

   // ---------------- assertions ----------------
   p_txsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_busy[CH_TX] && !soft_start) |=> $stable(txnum_q));
   p_mask_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_start |=> (mask_q == '0));
   p_txvec_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_flush_o) || (&tx_flush_o));
   p_frm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && frm_pend_q) |=> (frm_num_o == '0));
   p_soft_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_start |=> ((ch_busy == '0) && !frm_pend_q));
   p_ctrl_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_busy && !soft_start) |=> (ch_busy == '0));

endmodule

// File: tb/rstflush_ctrl_tb.sv
`timescale 1ns/1ps
module rstflush_ctrl_tb;

   localparam int unsigned NTX = 16;
   localparam int unsigned FC  = 8;
   localparam int unsigned FW  = 11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [1:0]      rd_addr = '0;
   logic [31:0]     rd_data;
   logic            dma_req_i = 1'b0;
   logic            mst_idle_i = 1'b1;
   logic            rst_done_i = 1'b0;
   logic            sof_i = 1'b0;
   logic [31:0]     irq_set_i = '0;
   logic            core_rst_o, bus_rst_o, intkn_flush_o, rx_flush_o, irq_o;
   logic [NTX-1:0]  tx_flush_o;
   logic [FW-1:0]   frm_num_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   rstflush_ctrl #(.NUM_TXF(NTX), .FLUSH_CYC(FC), .FRM_W(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .dma_req_i(dma_req_i),
      .mst_idle_i(mst_idle_i), .rst_done_i(rst_done_i), .sof_i(sof_i),
      .irq_set_i(irq_set_i), .core_rst_o(core_rst_o), .bus_rst_o(bus_rst_o),
      .intkn_flush_o(intkn_flush_o), .rx_flush_o(rx_flush_o),
      .tx_flush_o(tx_flush_o), .frm_num_o(frm_num_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #0.1;
      v = rd_data;
   endtask

   task automatic sof();
      @(negedge clk); sof_i = 1'b1;
      @(negedge clk); sof_i = 1'b0;
   endtask

   function automatic logic [NTX-1:0] exp_vec(input int code);
      if (code < NTX) return NTX'(1) << code;
      if (code == 16) return '1;
      return '0;
   endfunction

   initial begin : watchdog
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 32'h8000_0000);
      rd(2'd1, v); chk("R1 status", v, 0);
      rd(2'd2, v); chk("R1 mask", v, 0);
      rd(2'd3, v); chk("R1 cfg", v, 0);
      chk("R1 outputs", {core_rst_o, bus_rst_o, intkn_flush_o, rx_flush_o, irq_o, tx_flush_o, frm_num_o}, 0);

      // R10 read-only status bits
      dma_req_i = 1'b1; mst_idle_i = 1'b0;
      rd(2'd0, v); chk("R10 inputs shown", v, 32'h4000_0000);
      wr(2'd0, 32'hC000_0000);
      rd(2'd0, v); chk("R10 write ignored", v, 32'h4000_0000);
      dma_req_i = 1'b0; mst_idle_i = 1'b1;

      // R2 receive flush timing
      wr(2'd0, 32'h10);
      chk("R2 strobe", rx_flush_o, 1);
      rd(2'd0, v); chk("R2 bit set", v[4], 1);
      for (int k = 1; k <= FC; k++) begin
         step();
         rd(2'd0, v);
         if (k == 1) chk("R2 strobe one cycle", rx_flush_o, 0);
         chk("R2 bit duration", v[4], (k < FC) ? 1 : 0);
      end

      // R3 sweep every FIFO code
      for (int code = 0; code < 32; code++) begin
         wr(2'd0, (code << 6) | 32'h20);
         chk("R3 vector", tx_flush_o, exp_vec(code));
         rd(2'd0, v);
         chk("R3 field", v[10:6], code);
         chk("R3 bit set", v[5], 1);
         for (int k = 1; k <= FC; k++) begin
            step();
            if (k == 1) chk("R3 strobe one cycle", tx_flush_o, 0);
            if (k == FC - 1) begin rd(2'd0, v); chk("R3 still pending", v[5], 1); end
            if (k == FC)     begin rd(2'd0, v); chk("R3 cleared", v[5], 0); end
         end
      end

      // R4 field locked while pending
      wr(2'd0, (3 << 6) | 32'h20);
      chk("R4 first strobe", tx_flush_o, exp_vec(3));
      wr(2'd0, (7 << 6) | 32'h20);
      chk("R4 no new strobe", tx_flush_o, 0);
      rd(2'd0, v); chk("R4 field kept", v[10:6], 3);
      repeat (FC - 1) step();
      rd(2'd0, v); chk("R4 flush ended", v[5], 0);
      chk("R4 field after", v[10:6], 3);
      wr(2'd0, 9 << 6);
      rd(2'd0, v); chk("R4 field written idle", v[10:0], 9 << 6);
      chk("R4 no flush from field", tx_flush_o, 0);

      // R9 IN-token queue flush
      wr(2'd0, 32'h08);
      chk("R9 strobe", intkn_flush_o, 1);
      rd(2'd0, v); chk("R9 bit set", v[3], 1);
      step();
      chk("R9 strobe one cycle", intkn_flush_o, 0);
      rd(2'd0, v); chk("R9 bit cleared", v[3], 0);

      // R7 / R8 frame counter and bus reset
      repeat (3) sof();
      chk("R7 counting", frm_num_o, 3);
      wr(2'd0, 32'h02);
      chk("R8 strobe", bus_rst_o, 1);
      rd(2'd0, v); chk("R8 bit set", v[1], 1);
      step();
      chk("R8 strobe one cycle", bus_rst_o, 0);
      rd(2'd0, v); chk("R8 bit cleared", v[1], 0);
      chk("R8 frame untouched", frm_num_o, 3);
      wr(2'd0, 32'h04);
      step(); step();
      rd(2'd0, v); chk("R7 pending until sof", v[2], 1);
      chk("R7 number held", frm_num_o, 3);
      sof();
      chk("R7 restart at zero", frm_num_o, 0);
      rd(2'd0, v); chk("R7 bit cleared", v[2], 0);
      for (int i = 0; i < 2048; i++) sof();
      chk("R7 wrap", frm_num_o, 0);

      // R11 status / mask
      wr(2'd2, 32'h5);
      @(negedge clk); irq_set_i = 32'h6;
      @(negedge clk); irq_set_i = 32'h0;
      rd(2'd1, v); chk("R11 set", v, 32'h6);
      chk("R11 irq on", irq_o, 1);
      wr(2'd1, 32'h4);
      rd(2'd1, v); chk("R11 w1c", v, 32'h2);
      chk("R11 irq off", irq_o, 0);
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h2; irq_set_i = 32'h3;
      @(negedge clk); wr_en = 1'b0; irq_set_i = 32'h0;
      rd(2'd1, v); chk("R11 set wins", v, 32'h3);
      chk("R11 irq back", irq_o, 1);
      wr(2'd3, 32'hA5A5_1234);
      rd(2'd3, v); chk("R11 cfg rw", v, 32'hA5A5_1234);
      wr(2'd0, 32'h0);
      chk("R8 mask intact", irq_o, 1);

      // R6 / R5 soft reset
      wr(2'd0, 5 << 6);
      wr(2'd0, 32'h10);
      wr(2'd0, 32'h01);
      chk("R5 core reset high", core_rst_o, 1);
      chk("R6 rx strobe", rx_flush_o, 1);
      chk("R6 tx strobe all", tx_flush_o, {NTX{1'b1}});
      rd(2'd0, v); chk("R6 ctrl wiped", v, 32'h8000_0001);
      rd(2'd2, v); chk("R6 mask wiped", v, 0);
      rd(2'd1, v); chk("R6 status kept", v, 32'h3);
      rd(2'd3, v); chk("R6 cfg kept", v, 32'hA5A5_1234);
      chk("R6 irq masked", irq_o, 0);
      step();
      chk("R6 strobes end", {rx_flush_o, tx_flush_o}, 0);
      wr(2'd0, 32'h20);
      chk("R5 write ignored strobe", tx_flush_o, 0);
      rd(2'd0, v); chk("R5 write ignored ctrl", v, 32'h8000_0001);
      repeat (3) step();
      chk("R5 holds without done", core_rst_o, 1);
      mst_idle_i = 1'b0; rst_done_i = 1'b1;
      step(); step();
      chk("R5 holds without idle", core_rst_o, 1);
      rd(2'd0, v); chk("R5 ctrl during", v, 32'h0000_0001);
      mst_idle_i = 1'b1;
      step();
      chk("R5 released", core_rst_o, 0);
      rd(2'd0, v); chk("R5 ctrl after", v, 32'h8000_0000);
      rst_done_i = 1'b0;
      wr(2'd2, 32'h5);
      chk("R6 status survived", irq_o, 1);

      // R12 soft reset wins over other requests
      wr(2'd0, 32'h3F | (2 << 6));
      chk("R12 all tx from soft", tx_flush_o, {NTX{1'b1}});
      chk("R12 no bus strobe", {bus_rst_o, intkn_flush_o}, 0);
      rd(2'd0, v); chk("R12 only soft", v, 32'h8000_0001);
      rst_done_i = 1'b1;
      step();
      rst_done_i = 1'b0;
      rd(2'd0, v); chk("R12 nothing pending", v, 32'h8000_0000);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule